// File: doc/BRIEF.md
# Power-Good Startup and Power-Down Sequencer

This block brings a clock-generator device up from a single power-good pin and later moves it in and out of power-down from the same pin. The pin is synchronised and debounced. Its active level is chosen by a polarity register bit. On the first valid power-good, the block captures the address strap and the decoded three-level spread strap, and enables the PLL. It releases the differential outputs only after a stabilisation delay has run out and the PLL reports lock. A later loss of power-good enters power-down. A later return starts a shorter exit delay, after which the outputs are released again, also gated by lock.

The block also sets the state of the reference clock output. Before the first power-good the reference output is high impedance. In power-down it runs only if wake-on-LAN is enabled. In all other states it follows its own enable bit. The block drives the active spread code either from the captured strap or from a software override, and never passes on the reserved code. On every entry to power-down it can request that the register file return to its defaults.

Top module: `pgood_sequencer`

## Requirements
- R1: After reset the outputs are: ref_mode 00 (high impedance), pll_enable 0, out_release 0, power_down 0, cfg_restore 0, addr_sel 0, strap_spread 00, active_spread 00 while the override is off.
- R2: A level change on pg_pin that lasts fewer than FILT_CYCLES synchronised samples has no effect. pll_enable stays 0 and ref_mode stays 00.
- R3: On the first valid power-good, addr_sel and strap_spread capture their straps and pll_enable rises. Later strap changes are ignored until the next reset.
- R4: The strap encoding on spread_strap is 00 = low, 01 = mid, 10 = high, 11 = invalid. These map to strap_spread values: low → 00 (off), mid → 01 (−0.25%), high → 11 (−0.5%), invalid → 00.
- R5: out_release rises only after STAB_CYCLES cycles in the stabilisation state, and only in a cycle where pll_lock is 1. It stays 0 for as long as lock is absent.
- R6: After startup, loss of power-good clears out_release and pll_enable and sets power_down. A return of power-good sets pll_enable and releases the outputs after EXIT_CYCLES cycles with lock. Loss of power-good during either delay returns the block to power-down.
- R7: pd_active_high = 0 treats a low pin as power-down. pd_active_high = 1 treats a high pin as power-down.
- R8: ref_mode is 00 (high impedance) before the first power-good. In power-down it is 10 (running) when wol_enable = 1 and 01 (disabled) otherwise. In every other state it is 10 when ref_enable = 1 and 01 otherwise.
- R9: When spread_sw_en = 1, active_spread takes spread_sw_code, with the reserved code 10 replaced by 00. When spread_sw_en = 0, active_spread takes strap_spread.
- R10: cfg_restore pulses high for exactly one cycle on each entry to power-down when keep_config = 0. It never pulses when keep_config = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pg_pin | input | 1 | Raw power-good / power-down pin |
| pd_active_high | input | 1 | Polarity bit: 1 = power-down when pin high |
| addr_strap | input | 1 | Address strap level |
| spread_strap | input | 2 | Decoded three-level spread strap (00 low, 01 mid, 10 high) |
| pll_lock | input | 1 | PLL lock indication |
| ref_enable | input | 1 | Reference output enable bit |
| wol_enable | input | 1 | Keep reference running in power-down |
| keep_config | input | 1 | 1 = keep register configuration through power-down |
| spread_sw_en | input | 1 | Select software spread code |
| spread_sw_code | input | 2 | Software spread code |
| addr_sel | output | 1 | Captured address strap |
| strap_spread | output | 2 | Captured spread code (readback) |
| active_spread | output | 2 | Spread code in use |
| pll_enable | output | 1 | PLL run request |
| out_release | output | 1 | Differential outputs may run |
| power_down | output | 1 | Device is in power-down |
| cfg_restore | output | 1 | One-cycle request to restore register defaults |
| ref_mode | output | 2 | Reference output: 00 high-Z, 01 disabled, 10 running |

## Verification
The sharpest collision is the filtered loss of power-good landing in the same cycle in which the exit delay runs out with lock present. Power-down must win, and no release pulse may appear. The bench sweeps the length of a power-good return across a window around EXIT_CYCLES, so that the drop falls before, on and after the expiry cycle. A behavioural model is compared with every output on every clock, and it decides which event takes precedence. A second overlap is a wake-on-LAN or enable change in the cycle of power-down entry. The per-cycle comparison judges this through ref_mode.

// File: rtl/pgood_seq_pkg.sv
package pgood_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_STAB = 3'd1,
    ST_RUN  = 3'd2,
    ST_PD   = 3'd3,
    ST_EXIT = 3'd4
  } seq_state_e;

  typedef enum logic [1:0] {
    REF_HIZ = 2'b00,
    REF_OFF = 2'b01,
    REF_RUN = 2'b10
  } ref_mode_e;

  // decoded three-level strap -> spread code
  function automatic logic [1:0] strap_to_code(input logic [1:0] lvl);
    case (lvl)
      2'b00:   return 2'b00;
      2'b01:   return 2'b01;
      2'b10:   return 2'b11;
      default: return 2'b00;
    endcase
  endfunction

  // software code with the reserved value folded to spread off
  function automatic logic [1:0] clean_sw_code(input logic [1:0] c);
    return (c == 2'b10) ? 2'b00 : c;
  endfunction

endpackage

// File: rtl/pgood_filter.sv
module pgood_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_raw,
  output logic level
);
  localparam int CW = (FILT_CYCLES > 1) ? $clog2(FILT_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(FILT_CYCLES - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          hold_cnt;
  logic                   samp;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], pin_raw};
  end

  assign samp = sync_q[SYNC_STAGES-1];

  // the level moves only after the new value has been seen FILT_CYCLES times in a row
  always_ff @(posedge clk) begin
    if (rst) begin
      level    <= 1'b0;
      hold_cnt <= '0;
    end else if (samp == level) begin
      hold_cnt <= '0;
    end else if (hold_cnt == LAST) begin
      level    <= samp;
      hold_cnt <= '0;
    end else begin
      hold_cnt <= hold_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/strap_capture.sv
module strap_capture
  import pgood_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       capture,
  input  logic       addr_in,
  input  logic [1:0] tri_in,
  input  logic       sw_en,
  input  logic [1:0] sw_code,
  output logic       addr_q,
  output logic [1:0] strap_q,
  output logic [1:0] active_q
);
  logic [1:0] strap_nxt;

  assign strap_nxt = capture ? strap_to_code(tri_in) : strap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q   <= 1'b0;
      strap_q  <= 2'b00;
      active_q <= 2'b00;
    end else begin
      if (capture) addr_q <= addr_in;
      strap_q  <= strap_nxt;
      active_q <= sw_en ? clean_sw_code(sw_code) : strap_nxt;
    end
  end
endmodule

// File: rtl/pgood_fsm.sv
module pgood_fsm
  import pgood_seq_pkg::*;
#(
  parameter int STAB_CYCLES = 180000,
  parameter int EXIT_CYCLES = 30000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       good,
  input  logic       pll_lock,
  input  logic       keep_config,
  input  logic       ref_enable,
  input  logic       wol_enable,
  output logic       capture,
  output logic       pll_enable,
  output logic       out_release,
  output logic       power_down,
  output logic       cfg_restore,
  output logic [1:0] ref_mode
);
  localparam int MAXC = (STAB_CYCLES > EXIT_CYCLES) ? STAB_CYCLES : EXIT_CYCLES;
  localparam int TW   = $clog2(MAXC + 1);
  localparam logic [TW-1:0] STAB_LAST = TW'(STAB_CYCLES - 1);
  localparam logic [TW-1:0] EXIT_LAST = TW'(EXIT_CYCLES - 1);

  seq_state_e st, nxt;
  logic [TW-1:0] tmr;
  logic          tmr_done;
  ref_mode_e     ref_nxt;

  assign tmr_done = (tmr == ((st == ST_EXIT) ? EXIT_LAST : STAB_LAST));

  always_comb begin
    nxt     = st;
    capture = 1'b0;
    case (st)
      ST_IDLE: if (good) begin
                 nxt     = ST_STAB;
                 capture = 1'b1;
               end
      ST_STAB, ST_EXIT: begin
        if (!good)                    nxt = ST_PD;
        else if (tmr_done && pll_lock) nxt = ST_RUN;
      end
      ST_RUN:  if (!good) nxt = ST_PD;
      ST_PD:   if (good)  nxt = ST_EXIT;
      default: nxt = ST_IDLE;
    endcase
  end

  always_comb begin
    if (nxt == ST_IDLE)    ref_nxt = REF_HIZ;
    else if (nxt == ST_PD) ref_nxt = wol_enable ? REF_RUN : REF_OFF;
    else                   ref_nxt = ref_enable ? REF_RUN : REF_OFF;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= ST_IDLE;
      tmr <= '0;
    end else begin
      st <= nxt;
      if (nxt != st)     tmr <= '0;
      else if (!tmr_done) tmr <= tmr + 1'b1;
    end
  end

  // outputs registered from the next state
  always_ff @(posedge clk) begin
    if (rst) begin
      pll_enable  <= 1'b0;
      out_release <= 1'b0;
      power_down  <= 1'b0;
      cfg_restore <= 1'b0;
      ref_mode    <= REF_HIZ;
    end else begin
      pll_enable  <= (nxt == ST_STAB) || (nxt == ST_RUN) || (nxt == ST_EXIT);
      out_release <= (nxt == ST_RUN);
      power_down  <= (nxt == ST_PD);
      cfg_restore <= (nxt == ST_PD) && (st != ST_PD) && !keep_config;
      ref_mode    <= ref_nxt;
    end
  end
endmodule

// File: rtl/pgood_sequencer.sv
module pgood_sequencer #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CYCLES = 16,
  parameter int STAB_CYCLES = 180000,
  parameter int EXIT_CYCLES = 30000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pg_pin,
  input  logic       pd_active_high,
  input  logic       addr_strap,
  input  logic [1:0] spread_strap,
  input  logic       pll_lock,
  input  logic       ref_enable,
  input  logic       wol_enable,
  input  logic       keep_config,
  input  logic       spread_sw_en,
  input  logic [1:0] spread_sw_code,
  output logic       addr_sel,
  output logic [1:0] strap_spread,
  output logic [1:0] active_spread,
  output logic       pll_enable,
  output logic       out_release,
  output logic       power_down,
  output logic       cfg_restore,
  output logic [1:0] ref_mode
);
  logic pin_level;
  logic good;
  logic capture;

  pgood_filter #(
    .SYNC_STAGES(SYNC_STAGES),
    .FILT_CYCLES(FILT_CYCLES)
  ) u_filter (
    .clk    (clk),
    .rst    (rst),
    .pin_raw(pg_pin),
    .level  (pin_level)
  );

  assign good = pin_level ^ pd_active_high;

  pgood_fsm #(
    .STAB_CYCLES(STAB_CYCLES),
    .EXIT_CYCLES(EXIT_CYCLES)
  ) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .good       (good),
    .pll_lock   (pll_lock),
    .keep_config(keep_config),
    .ref_enable (ref_enable),
    .wol_enable (wol_enable),
    .capture    (capture),
    .pll_enable (pll_enable),
    .out_release(out_release),
    .power_down (power_down),
    .cfg_restore(cfg_restore),
    .ref_mode   (ref_mode)
  );

  strap_capture u_straps (
    .clk     (clk),
    .rst     (rst),
    .capture (capture),
    .addr_in (addr_strap),
    .tri_in  (spread_strap),
    .sw_en   (spread_sw_en),
    .sw_code (spread_sw_code),
    .addr_q  (addr_sel),
    .strap_q (strap_spread),
    .active_q(active_spread)
  );
endmodule

// File: rtl/pgood_sequencer_chk.sv
module pgood_sequencer_chk (
  input logic       clk,
  input logic       rst,
  input logic       pll_lock,
  input logic       addr_sel,
  input logic [1:0] strap_spread,
  input logic [1:0] active_spread,
  input logic       pll_enable,
  input logic       out_release,
  input logic       power_down,
  input logic       cfg_restore,
  input logic [1:0] ref_mode
);
  // R5
  release_locked_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(out_release) |-> $past(pll_lock));

  // R6
  release_running_chk: assert property (@(posedge clk) disable iff (rst)
    out_release |-> (pll_enable && !power_down));

  // R8
  ref_hiz_once_chk: assert property (@(posedge clk) disable iff (rst)
    (ref_mode != 2'b00) |=> (ref_mode != 2'b00));

  // R8
  pd_ref_driven_chk: assert property (@(posedge clk) disable iff (rst)
    power_down |-> (ref_mode != 2'b00));

  // R3
  strap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((ref_mode != 2'b00) && $past(ref_mode != 2'b00)) |-> ($stable(strap_spread) && $stable(addr_sel)));

  // R10
  restore_in_pd_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_restore |-> power_down);

  // R10
  restore_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_restore |=> !cfg_restore);

  // R9
  no_reserved_code_chk: assert property (@(posedge clk) disable iff (rst)
    (strap_spread != 2'b10) && (active_spread != 2'b10));
endmodule

bind pgood_sequencer pgood_sequencer_chk chk_i (
  .clk          (clk),
  .rst          (rst),
  .pll_lock     (pll_lock),
  .addr_sel     (addr_sel),
  .strap_spread (strap_spread),
  .active_spread(active_spread),
  .pll_enable   (pll_enable),
  .out_release  (out_release),
  .power_down   (power_down),
  .cfg_restore  (cfg_restore),
  .ref_mode     (ref_mode)
);

// File: tb/pgood_sequencer_test.sv
`timescale 1ns/1ps
module pgood_sequencer_test;
  localparam int FILT = 4;
  localparam int STAB = 20;
  localparam int EXIT = 8;
  localparam int M_IDLE = 0, M_STAB = 1, M_RUN = 2, M_PD = 3, M_EXIT = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pg_pin = 0, pol = 0, addr = 0, lock = 0, ref_en = 1, wol = 0, keep = 1, sw_en = 0;
  logic [1:0] strap = 2'b00, sw_code = 2'b00;
  logic addr_sel, pll_enable, out_release, power_down, cfg_restore;
  logic [1:0] strap_spread, active_spread, ref_mode;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  bit cmp_on = 0;

  always #10 clk = ~clk;

  pgood_sequencer #(
    .SYNC_STAGES(2), .FILT_CYCLES(FILT), .STAB_CYCLES(STAB), .EXIT_CYCLES(EXIT)
  ) uut (
    .clk(clk), .rst(rst), .pg_pin(pg_pin), .pd_active_high(pol),
    .addr_strap(addr), .spread_strap(strap), .pll_lock(lock),
    .ref_enable(ref_en), .wol_enable(wol), .keep_config(keep),
    .spread_sw_en(sw_en), .spread_sw_code(sw_code),
    .addr_sel(addr_sel), .strap_spread(strap_spread), .active_spread(active_spread),
    .pll_enable(pll_enable), .out_release(out_release), .power_down(power_down),
    .cfg_restore(cfg_restore), .ref_mode(ref_mode)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int map_strap(input int s);
    case (s)
      1: return 1;
      2: return 3;
      default: return 0;
    endcase
  endfunction

  // behavioural reference
  bit pin_q[$];
  int m_lvl, m_run, m_st, m_dwell;
  int e_addr, e_strap, e_spread, e_pll, e_rel, e_pd, e_clr, e_ref;

  always @(posedge clk) begin : model
    int sv, good, nst, lim, done;
    if (rst) begin
      pin_q = '{1'b0, 1'b0};
      m_lvl = 0; m_run = 0; m_st = M_IDLE; m_dwell = 0;
      e_addr = 0; e_strap = 0; e_spread = 0; e_pll = 0;
      e_rel = 0; e_pd = 0; e_clr = 0; e_ref = 0;
    end else begin
      good = m_lvl ^ int'(pol);
      lim  = (m_st == M_EXIT) ? EXIT : STAB;
      done = (m_dwell >= lim - 1);
      nst  = m_st;
      if (m_st == M_IDLE && good == 1) begin
        nst = M_STAB; e_addr = int'(addr); e_strap = map_strap(int'(strap));
      end else if (m_st == M_STAB || m_st == M_EXIT) begin
        if (good == 0) nst = M_PD;
        else if (done == 1 && lock) nst = M_RUN;
      end else if (m_st == M_RUN && good == 0) nst = M_PD;
      else if (m_st == M_PD && good == 1) nst = M_EXIT;
      e_spread = sw_en ? ((sw_code == 2'b10) ? 0 : int'(sw_code)) : e_strap;
      e_pll = (nst == M_STAB || nst == M_RUN || nst == M_EXIT);
      e_rel = (nst == M_RUN);
      e_pd  = (nst == M_PD);
      e_clr = (nst == M_PD && m_st != M_PD && !keep);
      if (nst == M_IDLE)    e_ref = 0;
      else if (nst == M_PD) e_ref = wol ? 2 : 1;
      else                  e_ref = ref_en ? 2 : 1;
      if (nst != m_st)          m_dwell = 0;
      else if (m_dwell < lim - 1) m_dwell++;
      m_st = nst;
      sv = int'(pin_q.pop_front());
      pin_q.push_back(pg_pin);
      if (sv == m_lvl) m_run = 0;
      else if (m_run == FILT - 1) begin m_lvl = sv; m_run = 0; end
      else m_run++;
    end
    #5;
    if (cmp_on) begin
      check("R3 addr_sel", int'(addr_sel), e_addr);
      check("R4 strap_spread", int'(strap_spread), e_strap);
      check("R9 active_spread", int'(active_spread), e_spread);
      check("R6 pll_enable", int'(pll_enable), e_pll);
      check("R5 out_release", int'(out_release), e_rel);
      check("R6 power_down", int'(power_down), e_pd);
      check("R10 cfg_restore", int'(cfg_restore), e_clr);
      check("R8 ref_mode", int'(ref_mode), e_ref);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; cyc(3); rst = 1'b0; cyc(1);
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    int pulses;
    @(negedge clk);
    cmp_on = 1;
    do_reset();
    // R1
    check("R1 ref_mode", int'(ref_mode), 0);
    check("R1 pll_enable", int'(pll_enable), 0);
    check("R1 out_release", int'(out_release), 0);
    check("R1 power_down", int'(power_down), 0);
    check("R1 strap_spread", int'(strap_spread), 0);
    // R2 glitch shorter than the filter
    pg_pin = 1; cyc(FILT - 1); pg_pin = 0; cyc(10);
    check("R2 pll_enable after glitch", int'(pll_enable), 0);
    check("R2 ref_mode after glitch", int'(ref_mode), 0);
    // R3 / R4 first power-good with mid strap
    strap = 2'b01; addr = 1; pg_pin = 1; cyc(10);
    check("R3 pll_enable", int'(pll_enable), 1);
    check("R4 mid strap code", int'(strap_spread), 1);
    check("R3 addr captured", int'(addr_sel), 1);
    strap = 2'b10; addr = 0; cyc(5);
    check("R3 strap ignored", int'(strap_spread), 1);
    check("R3 addr ignored", int'(addr_sel), 1);
    // R5 no release without lock
    cyc(STAB + 5);
    check("R5 held without lock", int'(out_release), 0);
    lock = 1; cyc(2);
    check("R5 release with lock", int'(out_release), 1);
    // R8 enable bit outside power-down
    ref_en = 0; cyc(2);
    check("R8 ref disabled", int'(ref_mode), 1);
    ref_en = 1; cyc(2);
    check("R8 ref running", int'(ref_mode), 2);
    // R9 override
    sw_en = 1; sw_code = 2'b10; cyc(2);
    check("R9 reserved folded", int'(active_spread), 0);
    sw_code = 2'b11; cyc(2);
    check("R9 override code", int'(active_spread), 3);
    sw_en = 0; cyc(2);
    check("R9 back to strap", int'(active_spread), 1);
    // R6 / R10 power-down with restore request
    keep = 0; wol = 0; pg_pin = 0; pulses = 0;
    for (int i = 0; i < 12; i++) begin cyc(1); if (cfg_restore) pulses++; end
    check("R10 one restore pulse", pulses, 1);
    check("R6 power_down", int'(power_down), 1);
    check("R6 release cleared", int'(out_release), 0);
    check("R8 ref off in pd", int'(ref_mode), 1);
    wol = 1; cyc(2);
    check("R8 wake-on-LAN ref", int'(ref_mode), 2);
    keep = 1;
    // R6 exit
    pg_pin = 1; cyc(8);
    check("R6 exit pll_enable", int'(pll_enable), 1);
    check("R6 exit not yet released", int'(out_release), 0);
    cyc(EXIT + 4);
    check("R6 exit released", int'(out_release), 1);
    // R7 polarity
    pol = 1; cyc(8);
    check("R7 high pin is power-down", int'(power_down), 1);
    pg_pin = 0; cyc(8 + EXIT + 4);
    check("R7 low pin runs", int'(out_release), 1);
    // collision sweep: power-good loss around exit expiry
    for (int k = EXIT - 3; k <= EXIT + 3; k++) begin
      pg_pin = 1; cyc(10);
      pg_pin = 0; cyc(k + 6);
      pg_pin = 1; cyc(10);
      check("R6 collision ends in power-down", int'(power_down), 1);
    end
    pg_pin = 0; cyc(EXIT + 15);
    check("R6 recovered", int'(out_release), 1);
    // R4 high strap after a fresh reset
    pol = 0; pg_pin = 0; strap = 2'b10; do_reset();
    pg_pin = 1; cyc(10);
    check("R4 high strap code", int'(strap_spread), 3);
    // R4 invalid strap, R10 no pulse with keep set
    pg_pin = 0; strap = 2'b11; do_reset();
    pg_pin = 1; cyc(10);
    check("R4 invalid strap code", int'(strap_spread), 0);
    cyc(STAB + 5);
    keep = 1; pg_pin = 0; pulses = 0;
    for (int i = 0; i < 12; i++) begin cyc(1); if (cfg_restore) pulses++; end
    check("R10 no pulse when kept", pulses, 0);
    cyc(2);
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule